// File: doc/BRIEF.md
# Battery charge cycle sequencer

This block steps a single-cell battery through one charge cycle. It chooses a current level for the analog charge loop, reports a 2-bit charge phase, controls the battery switch, raises a one-cycle interrupt when the cycle completes, and drives an open-drain indicator line. All decisions are made on 7-bit digital codes. Voltage codes are 20 mV per step above a 1900 mV floor: millivolts = 1900 + 20 × code. Current codes are compared directly with each other.

The state machine has six states: `S_OFF` (charging not allowed or not yet qualified), `S_SUSP` (external fault suspend), `S_SHORT` (deeply discharged battery), `S_PRE` (precharge), `S_FAST` (constant current and then constant voltage) and `S_DONE` (terminated). It has these transitions:
- Disable: any state goes to `S_OFF` when charging is not allowed.
- Suspend: any state goes to `S_SUSP` when the fault input is high.
- Resume: `S_SUSP` goes to `S_OFF` once the fault input clears.
- Qualify: `S_OFF` goes to the phase that the battery voltage selects.
- Phase move: `S_SHORT` and `S_PRE` move between themselves and to `S_FAST` as the battery voltage changes.
- Terminate: `S_FAST` goes to `S_DONE`.
- Recharge: `S_DONE` returns to the phase that the battery voltage selects.
- Overvoltage trip: every charging state goes to `S_OFF`.

Each threshold comparison except overvoltage passes through a persistence filter before the state machine sees it. The filter's output flips only after the raw comparison has disagreed with it on `DEB_SAMPLES` consecutive sample strobes. Strobes that are not consecutive clock cycles still count as consecutive samples.

Top module: `charge_cycle_seq`

## Requirements
- R1: Charging is allowed only when `chg_cfg_en`=1, `ce_n`=0 and `ichg_code`≠0. While it is not allowed, the block sits in `S_OFF` from the next clock: `isel`=00, `chg_stat`=00, `batsw_en`=1, `stat_pull`=0.
- R2: The current level is chosen from the filtered battery voltage. Below 2000 mV the block is in `S_SHORT` (`isel`=01, `chg_stat`=01). From 2000 mV up to the low-battery threshold it is in `S_PRE` (`isel`=10, `chg_stat`=01). At or above that threshold it is in `S_FAST` (`isel`=11, `chg_stat`=10).
- R3: `lowbat_hi`=1 sets the low-battery threshold to 3000 mV and `lowbat_hi`=0 sets it to 2800 mV.
- R4: A threshold crossing changes the state only after `DEB_SAMPLES` consecutive `smp_vld` samples agree. With one sample fewer, the state is unchanged.
- R5: `S_FAST` goes to `S_DONE` only when all of the following hold: the filtered termination condition is true (`ibat_code` < `iterm_code` and the battery is not below the recharge threshold), `in_reg`=0, and `therm_reg`=0.
- R6: With `term_en`=0 the block stays in `S_FAST` while the termination condition holds. Setting `term_en` back to 1 then terminates the cycle.
- R7: In `S_DONE`, `chg_stat`=11, `isel`=00 and `batsw_en`=0. `irq` is high for exactly the one cycle in which `S_DONE` is entered.
- R8: From `S_DONE` a new cycle starts when the filtered battery voltage falls below the regulation voltage minus 100 mV (`rechg_wide`=0) or minus 200 mV (`rechg_wide`=1).
- R9: Taking charging away and giving it back (by a toggle of `ce_n` or of `chg_cfg_en`) starts a new cycle from `S_OFF`.
- R10: A sample above the regulation voltage plus 4% (25·vbat > 26·vreg in mV) moves every charging state to `S_OFF` at that sample, with no persistence. The block stays in `S_OFF` until a sample is back below that limit.
- R11: `stat_pull`=1 in `S_SHORT`, `S_PRE` and `S_FAST`, and 0 in `S_OFF` and `S_DONE`. `stat_dis`=1 forces `stat_pull` to 0 in every state.
- R12: In `S_SUSP` (`chg_stat`=00, `isel`=00), `stat_pull` is 1 for the first `BLINK_HALF` cycles after entry. It then alternates every `BLINK_HALF` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Strobe marking a new pair of battery voltage and current codes |
| vbat_code | input | 7 | Battery voltage code |
| ibat_code | input | 7 | Battery charge current code |
| chg_cfg_en | input | 1 | Charge configuration enable |
| ce_n | input | 1 | Active-low charge enable |
| ichg_code | input | 7 | Fast-charge current setting; zero disables charging |
| iterm_code | input | 7 | Termination current level |
| vreg_code | input | 7 | Regulation voltage code |
| lowbat_hi | input | 1 | Low-battery threshold select (1: 3000 mV, 0: 2800 mV) |
| rechg_wide | input | 1 | Recharge offset select (1: 200 mV, 0: 100 mV) |
| term_en | input | 1 | Termination enable |
| stat_dis | input | 1 | Indicator line disable |
| in_reg | input | 1 | Input current or voltage regulation active |
| therm_reg | input | 1 | Thermal regulation active |
| fault_susp | input | 1 | Fault suspend request |
| isel | output | 2 | Current level select: 00 none, 01 short, 10 precharge, 11 fast |
| chg_stat | output | 2 | Charge status: 00 off, 01 pre/short, 10 fast, 11 done |
| batsw_en | output | 1 | Battery switch enable |
| irq | output | 1 | Interrupt request pulse on termination |
| stat_pull | output | 1 | Open-drain pull-down drive for the indicator line |

## Verification
The bench walks battery voltage codes across the boundaries that matter for each decision:
- short versus precharge at code 4/5;
- both low-battery settings using code 50, which falls on different sides of the two thresholds;
- the recharge points 109/110 and 104/105;
- the overvoltage point 123/124.

Each pattern is held for one sample fewer and then for exactly the persistence count, so a wrong filter length is caught. Termination is tried with each gating input raised alone and with termination disabled, which separates an ungated transition from a correct one. The indicator line is observed across a whole blink period and against the disable bit.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

    typedef enum logic [2:0] {
        S_OFF   = 3'd0,
        S_SUSP  = 3'd1,
        S_SHORT = 3'd2,
        S_PRE   = 3'd3,
        S_FAST  = 3'd4,
        S_DONE  = 3'd5
    } chg_state_e;

    typedef enum logic [1:0] {
        ISEL_NONE  = 2'd0,
        ISEL_SHORT = 2'd1,
        ISEL_PRE   = 2'd2,
        ISEL_FAST  = 2'd3
    } isel_e;

    localparam int FLT_SHORT = 0;
    localparam int FLT_LOW   = 1;
    localparam int FLT_RECHG = 2;
    localparam int FLT_TERM  = 3;
    localparam int FLT_NUM   = 4;

endpackage

// File: rtl/chg_thresholds.sv
module chg_thresholds #(
    parameter int CODE_W         = 7,
    parameter int MV_W           = 13,
    parameter int OFS_MV         = 1900,
    parameter int LSB_MV         = 20,
    parameter int SHORT_MV       = 2000,
    parameter int LOWBAT_LO_MV   = 2800,
    parameter int LOWBAT_HI_MV   = 3000,
    parameter int RCHG_NARROW_MV = 100,
    parameter int RCHG_WIDE_MV   = 200
) (
    input  logic [CODE_W-1:0] vbat_code,
    input  logic [CODE_W-1:0] vreg_code,
    input  logic [CODE_W-1:0] ibat_code,
    input  logic [CODE_W-1:0] iterm_code,
    input  logic              lowbat_hi,
    input  logic              rechg_wide,
    output logic              raw_short,
    output logic              raw_low,
    output logic              raw_rechg,
    output logic              raw_term,
    output logic              raw_ovp
);
    localparam int OV_W = MV_W + 5;

    logic [MV_W-1:0] vbat_mv, vreg_mv, low_mv, rechg_mv;

    always_comb begin
        vbat_mv  = MV_W'(OFS_MV) + MV_W'(vbat_code) * MV_W'(LSB_MV);
        vreg_mv  = MV_W'(OFS_MV) + MV_W'(vreg_code) * MV_W'(LSB_MV);
        low_mv   = lowbat_hi ? MV_W'(LOWBAT_HI_MV) : MV_W'(LOWBAT_LO_MV);
        rechg_mv = vreg_mv - (rechg_wide ? MV_W'(RCHG_WIDE_MV) : MV_W'(RCHG_NARROW_MV));
        raw_short = vbat_mv < MV_W'(SHORT_MV);
        raw_low   = vbat_mv < low_mv;
        raw_rechg = vbat_mv < rechg_mv;
        raw_term  = (ibat_code < iterm_code) && !raw_rechg;
        // 4 % above regulation: 25*vbat > 26*vreg
        raw_ovp   = (OV_W'(vbat_mv) * OV_W'(25)) > (OV_W'(vreg_mv) * OV_W'(26));
    end

endmodule

// File: rtl/chg_persist.sv
module chg_persist #(
    parameter int SAMPLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_vld,
    input  logic raw,
    output logic flt
);
    localparam int CNT_W = $clog2(SAMPLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            flt <= 1'b0;
        end else if (smp_vld) begin
            if (raw == flt) begin
                cnt <= '0;
            end else if (cnt == CNT_W'(SAMPLES - 1)) begin
                cnt <= '0;
                flt <= raw;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/chg_stat_drive.sv
module chg_stat_drive #(
    parameter int BLINK_HALF = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic blink_en,
    input  logic charging,
    input  logic stat_dis,
    output logic stat_pull
);
    localparam int BC_W = $clog2(BLINK_HALF + 1);

    logic [BC_W-1:0] bcnt;
    logic            phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt  <= '0;
            phase <= 1'b1;
        end else if (!blink_en) begin
            bcnt  <= '0;
            phase <= 1'b1;
        end else if (bcnt == BC_W'(BLINK_HALF - 1)) begin
            bcnt  <= '0;
            phase <= ~phase;
        end else begin
            bcnt <= bcnt + 1'b1;
        end
    end

    assign stat_pull = !stat_dis && (charging || (blink_en && phase));

endmodule

// File: rtl/charge_cycle_seq.sv
module charge_cycle_seq
    import chg_seq_pkg::*;
#(
    parameter int CODE_W      = 7,
    parameter int OFS_MV      = 1900,
    parameter int LSB_MV      = 20,
    parameter int DEB_SAMPLES = 3,
    parameter int BLINK_HALF  = 25_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [CODE_W-1:0] vbat_code,
    input  logic [CODE_W-1:0] ibat_code,
    input  logic              chg_cfg_en,
    input  logic              ce_n,
    input  logic [CODE_W-1:0] ichg_code,
    input  logic [CODE_W-1:0] iterm_code,
    input  logic [CODE_W-1:0] vreg_code,
    input  logic              lowbat_hi,
    input  logic              rechg_wide,
    input  logic              term_en,
    input  logic              stat_dis,
    input  logic              in_reg,
    input  logic              therm_reg,
    input  logic              fault_susp,
    output logic [1:0]        isel,
    output logic [1:0]        chg_stat,
    output logic              batsw_en,
    output logic              irq,
    output logic              stat_pull
);
    localparam int MV_W = $clog2(OFS_MV + ((1 << CODE_W) - 1) * LSB_MV + 1);

    chg_state_e         state, state_nxt;
    logic [FLT_NUM-1:0] raw_v, flt_v;
    logic               raw_ovp, ovp_q, ovp_now;
    logic               chg_en, term_ok, charging;
    chg_state_e         pick;

    chg_thresholds #(
        .CODE_W(CODE_W), .MV_W(MV_W), .OFS_MV(OFS_MV), .LSB_MV(LSB_MV)
    ) thr_i (
        .vbat_code (vbat_code),
        .vreg_code (vreg_code),
        .ibat_code (ibat_code),
        .iterm_code(iterm_code),
        .lowbat_hi (lowbat_hi),
        .rechg_wide(rechg_wide),
        .raw_short (raw_v[FLT_SHORT]),
        .raw_low   (raw_v[FLT_LOW]),
        .raw_rechg (raw_v[FLT_RECHG]),
        .raw_term  (raw_v[FLT_TERM]),
        .raw_ovp   (raw_ovp)
    );

    for (genvar g = 0; g < FLT_NUM; g++) begin : g_flt
        chg_persist #(.SAMPLES(DEB_SAMPLES)) flt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .smp_vld(smp_vld),
            .raw    (raw_v[g]),
            .flt    (flt_v[g])
        );
    end

    // overvoltage acts on the sample itself, then holds until the next one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovp_q <= 1'b0;
        else if (smp_vld) ovp_q <= raw_ovp;
    end

    always_comb begin
        ovp_now = smp_vld ? raw_ovp : ovp_q;
        chg_en  = chg_cfg_en && !ce_n && (ichg_code != '0);
        term_ok = flt_v[FLT_TERM] && term_en && !in_reg && !therm_reg;
        if (flt_v[FLT_SHORT])    pick = S_SHORT;
        else if (flt_v[FLT_LOW]) pick = S_PRE;
        else                     pick = S_FAST;
    end

    always_comb begin
        state_nxt = state;
        if (!chg_en) begin
            state_nxt = S_OFF;
        end else if (fault_susp) begin
            state_nxt = S_SUSP;
        end else begin
            unique case (state)
                S_OFF:          if (!ovp_now) state_nxt = pick;
                S_SUSP:         state_nxt = S_OFF;
                S_SHORT, S_PRE: state_nxt = ovp_now ? S_OFF : pick;
                S_FAST: begin
                    if (ovp_now)      state_nxt = S_OFF;
                    else if (term_ok) state_nxt = S_DONE;
                end
                S_DONE: begin
                    if (ovp_now)               state_nxt = S_OFF;
                    else if (flt_v[FLT_RECHG]) state_nxt = pick;
                end
                default: state_nxt = S_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_OFF;
            irq   <= 1'b0;
        end else begin
            state <= state_nxt;
            irq   <= (state_nxt == S_DONE) && (state != S_DONE);
        end
    end

    // outputs
    always_comb begin
        isel     = ISEL_NONE;
        chg_stat = 2'b00;
        batsw_en = 1'b1;
        charging = 1'b0;
        unique case (state)
            S_SHORT: begin isel = ISEL_SHORT; chg_stat = 2'b01; charging = 1'b1; end
            S_PRE:   begin isel = ISEL_PRE;   chg_stat = 2'b01; charging = 1'b1; end
            S_FAST:  begin isel = ISEL_FAST;  chg_stat = 2'b10; charging = 1'b1; end
            S_DONE:  begin chg_stat = 2'b11; batsw_en = 1'b0; end
            S_OFF, S_SUSP: ;
            default: ;
        endcase
    end

    chg_stat_drive #(.BLINK_HALF(BLINK_HALF)) stat_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .blink_en (state == S_SUSP),
        .charging (charging),
        .stat_dis (stat_dis),
        .stat_pull(stat_pull)
    );

endmodule

// File: rtl/chg_seq_checker.sv
module chg_seq_checker #(
    parameter int CODE_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chg_cfg_en,
    input logic              ce_n,
    input logic [CODE_W-1:0] ichg_code,
    input logic              term_en,
    input logic              in_reg,
    input logic              therm_reg,
    input logic              stat_dis,
    input logic [1:0]        isel,
    input logic [1:0]        chg_stat,
    input logic              batsw_en,
    input logic              irq,
    input logic              stat_pull
);

    assert_disable_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(chg_cfg_en && !ce_n && (ichg_code != '0)) |=> (isel == 2'b00 && chg_stat == 2'b00));

    assert_done_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_stat == 2'b11 && $past(chg_stat) != 2'b11) |-> $past(term_en && !in_reg && !therm_reg));

    assert_irq_in_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (chg_stat == 2'b11 && !batsw_en));

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_stat_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_dis |-> !stat_pull);

endmodule

bind charge_cycle_seq chg_seq_checker #(.CODE_W(CODE_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .chg_cfg_en(chg_cfg_en),
    .ce_n      (ce_n),
    .ichg_code (ichg_code),
    .term_en   (term_en),
    .in_reg    (in_reg),
    .therm_reg (therm_reg),
    .stat_dis  (stat_dis),
    .isel      (isel),
    .chg_stat  (chg_stat),
    .batsw_en  (batsw_en),
    .irq       (irq),
    .stat_pull (stat_pull)
);

// File: tb/charge_cycle_seq_tb_top.sv
module charge_cycle_seq_tb_top;

    localparam int N    = 3;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_vld = 1'b0;
    logic [6:0] vbat_code = 7'd80, ibat_code = 7'd100;
    logic       chg_cfg_en = 1'b1, ce_n = 1'b1;
    logic [6:0] ichg_code = 7'd50, iterm_code = 7'd20, vreg_code = 7'd115;
    logic       lowbat_hi = 1'b1, rechg_wide = 1'b0, term_en = 1'b1;
    logic       stat_dis = 1'b0, in_reg = 1'b0, therm_reg = 1'b0, fault_susp = 1'b0;
    logic [1:0] isel, chg_stat;
    logic       batsw_en, irq, stat_pull;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    charge_cycle_seq #(.DEB_SAMPLES(N), .BLINK_HALF(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .vbat_code(vbat_code),
        .ibat_code(ibat_code), .chg_cfg_en(chg_cfg_en), .ce_n(ce_n),
        .ichg_code(ichg_code), .iterm_code(iterm_code), .vreg_code(vreg_code),
        .lowbat_hi(lowbat_hi), .rechg_wide(rechg_wide), .term_en(term_en),
        .stat_dis(stat_dis), .in_reg(in_reg), .therm_reg(therm_reg),
        .fault_susp(fault_susp), .isel(isel), .chg_stat(chg_stat),
        .batsw_en(batsw_en), .irq(irq), .stat_pull(stat_pull)
    );

    // expected tuples {isel, chg_stat, batsw_en, stat_pull}
    localparam logic [5:0] E_OFF   = 6'b00_00_1_0;
    localparam logic [5:0] E_SHORT = 6'b01_01_1_1;
    localparam logic [5:0] E_PRE   = 6'b10_01_1_1;
    localparam logic [5:0] E_FAST  = 6'b11_10_1_1;
    localparam logic [5:0] E_DONE  = 6'b00_11_0_0;

    task automatic expect_out(input string req, input logic [5:0] exp);
        logic [5:0] act;
        act = {isel, chg_stat, batsw_en, stat_pull};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s outputs actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic expect_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s bit actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic smp(input logic [6:0] v, input logic [6:0] i, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            vbat_code = v;
            ibat_code = i;
            smp_vld   = 1'b1;
            @(negedge clk);
            smp_vld   = 1'b0;
        end
        step(1);
    endtask

    task automatic t_reset;
        expect_out("R1 reset", E_OFF);
        expect_bit("R7 reset irq", irq, 1'b0);
    endtask

    task automatic t_enable;
        smp(7'd80, 7'd100, N);
        ichg_code = 7'd0; ce_n = 1'b0; step(2);
        expect_out("R1 zero current code", E_OFF);
        ichg_code = 7'd50; step(2);
        expect_out("R1 all enables", E_FAST);
        chg_cfg_en = 1'b0; step(2);
        expect_out("R1 config bit off", E_OFF);
        chg_cfg_en = 1'b1; step(2);
        expect_out("R1 config bit on", E_FAST);
        ce_n = 1'b1; step(2);
        expect_out("R1 ce high", E_OFF);
    endtask

    task automatic t_phases;
        smp(7'd3, 7'd100, N);
        ce_n = 1'b0; step(2);
        expect_out("R2 short phase", E_SHORT);
        smp(7'd30, 7'd100, N - 1);
        expect_out("R4 one sample short", E_SHORT);
        smp(7'd30, 7'd100, 1);
        expect_out("R2 R4 precharge", E_PRE);
        smp(7'd70, 7'd100, N);
        expect_out("R2 fast phase", E_FAST);
        ce_n = 1'b1; step(2);
    endtask

    task automatic t_lowbat;
        lowbat_hi = 1'b1;
        smp(7'd50, 7'd100, N);
        ce_n = 1'b0; step(2);
        expect_out("R3 3.0V threshold", E_PRE);
        ce_n = 1'b1; lowbat_hi = 1'b0;
        smp(7'd50, 7'd100, N);
        ce_n = 1'b0; step(2);
        expect_out("R3 2.8V threshold", E_FAST);
        lowbat_hi = 1'b1;
    endtask

    task automatic t_term;
        smp(7'd112, 7'd100, N);
        expect_out("R5 fast before term", E_FAST);
        in_reg = 1'b1;
        smp(7'd112, 7'd10, N);
        expect_out("R5 input regulation gates", E_FAST);
        @(negedge clk); in_reg = 1'b0; therm_reg = 1'b1; step(2);
        expect_out("R5 thermal regulation gates", E_FAST);
        therm_reg = 1'b0; step(1);
        expect_out("R7 done outputs", E_DONE);
        expect_bit("R7 irq pulse", irq, 1'b1);
        step(1);
        expect_bit("R7 irq single cycle", irq, 1'b0);
    endtask

    task automatic t_recharge;
        smp(7'd110, 7'd10, N);
        expect_out("R8 narrow at threshold", E_DONE);
        smp(7'd109, 7'd10, N);
        expect_out("R8 narrow recharge", E_FAST);
        rechg_wide = 1'b1;
        smp(7'd112, 7'd10, N);
        expect_out("R8 done again", E_DONE);
        smp(7'd105, 7'd10, N);
        expect_out("R8 wide at threshold", E_DONE);
        smp(7'd104, 7'd10, N);
        expect_out("R8 wide recharge", E_FAST);
        rechg_wide = 1'b0;
    endtask

    task automatic t_term_dis;
        term_en = 1'b0;
        smp(7'd112, 7'd10, N + 2);
        expect_out("R6 termination disabled", E_FAST);
        @(negedge clk); term_en = 1'b1; step(1);
        expect_out("R6 termination re-enabled", E_DONE);
    endtask

    task automatic t_restart;
        ce_n = 1'b1; step(2);
        expect_out("R9 ce toggle off", E_OFF);
        smp(7'd112, 7'd100, N);
        ce_n = 1'b0; step(2);
        expect_out("R9 ce toggle new cycle", E_FAST);
        smp(7'd112, 7'd10, N);
        expect_out("R9 done before config toggle", E_DONE);
        chg_cfg_en = 1'b0; step(2);
        expect_out("R9 config toggle off", E_OFF);
        smp(7'd112, 7'd100, N);
        chg_cfg_en = 1'b1; step(2);
        expect_out("R9 config toggle new cycle", E_FAST);
    endtask

    task automatic t_ovp;
        smp(7'd123, 7'd100, 1);
        expect_out("R10 just below limit", E_FAST);
        smp(7'd124, 7'd100, 1);
        expect_out("R10 trip on one sample", E_OFF);
        step(3);
        expect_out("R10 held off", E_OFF);
        smp(7'd112, 7'd100, 1);
        expect_out("R10 recovered", E_FAST);
    endtask

    task automatic t_stat;
        stat_dis = 1'b1; step(1);
        expect_out("R11 disable in fast", 6'b11_10_1_0);
        stat_dis = 1'b0;
        @(negedge clk); fault_susp = 1'b1; step(1);
        expect_out("R12 suspend entry", 6'b00_00_1_1);
        step(HALF - 1);
        expect_bit("R12 end of first half", stat_pull, 1'b1);
        step(1);
        expect_bit("R12 second half released", stat_pull, 1'b0);
        step(HALF);
        expect_bit("R12 third half pulled", stat_pull, 1'b1);
        stat_dis = 1'b1; step(1);
        expect_bit("R11 disable in suspend", stat_pull, 1'b0);
        stat_dis = 1'b0; fault_susp = 1'b0; step(3);
        expect_out("R12 resume after fault", E_FAST);
        ce_n = 1'b1; step(2);
        expect_out("R11 released when off", E_OFF);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_enable();
        t_phases();
        t_lowbat();
        t_term();
        t_recharge();
        t_term_dis();
        t_restart();
        t_ovp();
        t_stat();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule